// File: doc/BRIEF.md
# Byte-Accessed Up/Down Timer Counter

This block holds a 16-bit counter that moves up or down by one on each timer tick. A processor reaches it over an 8-bit bus that has two byte addresses. The high-byte address never touches the counter directly. It always reaches a hidden 8-bit holding register. Reading the low byte fills that holding register with the counter's high byte at the same edge, so a later high-byte read returns a value that matches the low byte already taken. Writing the low byte loads all sixteen bits in one cycle: the low byte comes from the bus and the high byte from the holding register. Software therefore writes the high byte first and the low byte last, and reads the low byte first and the high byte last.

The tick comes from a 3-bit source selector. The selector can stop the counter, tick on every system clock, pick one of four prescaler strobes supplied from outside, or follow the falling or rising edges of an external pin, which is synchronised first. A clear input, a direction input and the bus write decide the next value, in a fixed priority. Two status outputs flag the all-ones and zero values. A sticky overflow flag records each upward wrap.

The bus carries no back-pressure and accepts one access every cycle. `bus_rdata` is combinational from `bus_addr`. Control and status pins are plain levels and one-cycle strobes.

Top module: `bytectr16_top`

## Requirements
- R1: After reset the counter, the holding register and the overflow flag are all zero, so `at_bottom` is 1.
- R2: On a tick the counter adds one when `cnt_down`=0 and subtracts one when `cnt_down`=1, wrapping modulo 65536.
- R3: A cycle with `cnt_clear`=1 sets the counter to zero at the next edge, whether or not a tick is present.
- R4: A write with `bus_addr`=1 changes only the holding register. A read with `bus_addr`=1 returns the holding register.
- R5: `bus_rdata` with `bus_addr`=0 shows the counter low byte. A read (`bus_rd`=1, `bus_wr`=0) at that address copies the counter high byte into the holding register at the same edge.
- R6: A write with `bus_addr`=0 loads the counter with {holding register, `bus_wdata`} at the next edge.
- R7: A low-byte write takes priority over a clear and over a tick in the same cycle.
- R8: With `clk_sel`=0 the counter never changes except through a bus write. Prescaler strobes and pin activity have no effect.
- R9: `clk_sel`=1 ticks every cycle. `clk_sel`=2,3,4,5 tick on `pre_stb[0]`, `[1]`, `[2]`, `[3]` (the divide-by-8, 64, 256 and 1024 strobes).
- R10: `clk_sel`=6 ticks once per falling edge of `ext_pin` and `clk_sel`=7 once per rising edge. If the pin changes before clock edge k, the counter changes at edge k+2.
- R11: `at_top` is 1 exactly when the counter is 16'hFFFF. `at_bottom` is 1 exactly when it is zero.
- R12: `ovf_flag` becomes 1 when an upward tick moves the counter from 16'hFFFF to 0. It stays 1 until an `ovf_clr` pulse clears it. A wrap in the same cycle as `ovf_clr` leaves it set, and a downward wrap never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Byte select: 0 low byte, 1 high/holding byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (its side effect only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| clk_sel | input | 3 | Tick source select |
| pre_stb | input | 4 | Prescaler tick strobes (/8, /64, /256, /1024) |
| ext_pin | input | 1 | Asynchronous external tick pin |
| cnt_down | input | 1 | Direction: 0 up, 1 down |
| cnt_clear | input | 1 | Synchronous clear to zero |
| ovf_clr | input | 1 | Clears the overflow flag |
| at_top | output | 1 | Counter equals 16'hFFFF |
| at_bottom | output | 1 | Counter equals zero |
| ovf_flag | output | 1 | Sticky overflow request |

## Verification
Counting is swept over start values that sit at byte and word boundaries, in both directions and over several run lengths. Each result is compared with modular arithmetic, so a carry lost between the bytes and a wrong wrap direction show up as different failures. Each prescaler select runs against four strobes pulsing at different rates, which shows whether the selector picks the right strobe, and the pin edges are counted separately for each polarity. Snapshot reads taken while the counter runs across a high-byte carry separate an atomic read from a torn one. Write, clear and tick in the same cycle expose the priority order.

// File: rtl/bytectr16_pkg.sv
package bytectr16_pkg;
  localparam int BUS_W = 8;
  localparam int CNT_W = 2 * BUS_W;
  localparam int N_PRE = 4;

  typedef enum logic [2:0] {
    SRC_OFF      = 3'd0,
    SRC_SYSCLK   = 3'd1,
    SRC_PRE0     = 3'd2,
    SRC_PRE1     = 3'd3,
    SRC_PRE2     = 3'd4,
    SRC_PRE3     = 3'd5,
    SRC_PIN_FALL = 3'd6,
    SRC_PIN_RISE = 3'd7
  } tick_src_e;

  localparam logic ADDR_LO = 1'b0;
  localparam logic ADDR_HI = 1'b1;
endpackage

// File: rtl/tick_select.sv
module tick_select
  import bytectr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel,
  input  logic [N_PRE-1:0] pre_stb,
  input  logic             ext_pin,
  output logic             tick
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] pin_sh;
  logic            pin_rise, pin_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_sh <= '0;
    else        pin_sh <= {pin_sh[SH_W-2:0], ext_pin};
  end

  assign pin_rise =  pin_sh[SYNC_STAGES-1] & ~pin_sh[SYNC_STAGES];
  assign pin_fall = ~pin_sh[SYNC_STAGES-1] &  pin_sh[SYNC_STAGES];

  always_comb begin
    unique case (tick_src_e'(sel))
      SRC_OFF:      tick = 1'b0;
      SRC_SYSCLK:   tick = 1'b1;
      SRC_PRE0:     tick = pre_stb[0];
      SRC_PRE1:     tick = pre_stb[1];
      SRC_PRE2:     tick = pre_stb[2];
      SRC_PRE3:     tick = pre_stb[3];
      SRC_PIN_FALL: tick = pin_fall;
      SRC_PIN_RISE: tick = pin_rise;
      default:      tick = 1'b0;
    endcase
  end

  // R10: a rising-edge tick needs the pin high two edges earlier
  assert_pin_rise_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_PIN_RISE && tick) |-> $past(ext_pin, 2));
  // R10: a falling-edge tick needs the pin low two edges earlier
  assert_pin_fall_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_PIN_FALL && tick) |-> !$past(ext_pin, 2));
endmodule

// File: rtl/byte_port.sv
module byte_port
  import bytectr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  output logic [BUS_W-1:0] rdata,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  logic [BUS_W-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold <= '0;
    else if (wr && addr == ADDR_HI)
      hold <= wdata;
    else if (rd && !wr && addr == ADDR_LO)
      hold <= cnt[CNT_W-1:BUS_W];
  end

  assign rdata    = (addr == ADDR_HI) ? hold : cnt[BUS_W-1:0];
  assign load     = wr && (addr == ADDR_LO);
  assign load_val = {hold, wdata};

  // R4: a high-byte write lands in the holding register
  assert_hold_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_HI) |=> (hold == $past(wdata)));
  // R5: a low-byte read snapshots the counter high byte
  assert_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && addr == ADDR_LO) |=> (hold == $past(cnt[CNT_W-1:BUS_W])));
endmodule

// File: rtl/count_core.sv
module count_core
  import bytectr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             down,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             at_top,
  output logic             at_bottom,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};

  logic wrap_up;

  assign wrap_up = tick && !down && !clr && !load && (cnt == TOP_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (clr)        cnt <= '0;
    else if (tick)       cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (wrap_up) ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  assign at_top    = (cnt == TOP_VAL);
  assign at_bottom = (cnt == '0);

  // R7: a bus load beats clear and tick
  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
  // R3: clear without a load gives zero
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> (cnt == '0));
  // R8: no tick, no clear, no load: counter holds
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr && !load) |=> $stable(cnt));
  // R12: overflow rises only after an upward step from all ones
  assert_ovf_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(cnt) == TOP_VAL && !$past(down) && cnt == '0));
endmodule

// File: rtl/bytectr16_top.sv
module bytectr16_top
  import bytectr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [2:0]       clk_sel,
  input  logic [N_PRE-1:0] pre_stb,
  input  logic             ext_pin,
  input  logic             cnt_down,
  input  logic             cnt_clear,
  input  logic             ovf_clr,
  output logic             at_top,
  output logic             at_bottom,
  output logic             ovf_flag
);
  logic             tick;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;

  tick_select #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (clk_sel),
    .pre_stb (pre_stb),
    .ext_pin (ext_pin),
    .tick    (tick)
  );

  byte_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wdata    (bus_wdata),
    .cnt      (cnt),
    .rdata    (bus_rdata),
    .load     (load),
    .load_val (load_val)
  );

  count_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .down      (cnt_down),
    .clr       (cnt_clear),
    .load      (load),
    .load_val  (load_val),
    .ovf_clr   (ovf_clr),
    .cnt       (cnt),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .ovf       (ovf_flag)
  );

  // R11: the two status flags never agree on a true value
  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_top && at_bottom));
endmodule

// File: tb/sim_bytectr16_top.sv
`timescale 1ns/1ps
module sim_bytectr16_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] clk_sel = '0;
  logic [3:0] pre_stb = '0;
  logic       ext_pin = 1'b0, cnt_down = 1'b0, cnt_clear = 1'b0, ovf_clr = 1'b0;
  logic       at_top, at_bottom, ovf_flag;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  bytectr16_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_sel(clk_sel), .pre_stb(pre_stb),
    .ext_pin(ext_pin), .cnt_down(cnt_down), .cnt_clear(cnt_clear), .ovf_clr(ovf_clr),
    .at_top(at_top), .at_bottom(at_bottom), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr16(input logic [15:0] v);
    @(negedge clk); bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = v[15:8];
    @(negedge clk); bus_addr = 1'b0; bus_wdata = v[7:0];
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    @(negedge clk); bus_addr = 1'b0; bus_rd = 1'b1; #1 v[7:0] = bus_rdata;
    @(negedge clk); bus_addr = 1'b1; #1 v[15:8] = bus_rdata;
    bus_rd = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic clr_ovf();
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] starts [8];
    int ks [4];
    starts = '{16'h0000, 16'h0001, 16'h00FF, 16'h0100, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
    ks = '{1, 2, 3, 7};

    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    bus_addr = 1'b1; #1 chk("R1 hold", bus_rdata, 8'h00);
    bus_addr = 1'b0; #1 chk("R1 low", bus_rdata, 8'h00);
    chk("R1 bottom", at_bottom, 1'b1);
    chk("R1 ovf", ovf_flag, 1'b0);

    // R2 / R12 sweep over boundary starts, both directions, several lengths
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int ki = 0; ki < 4; ki++) begin
          logic [16:0] sum;
          logic [15:0] exp;
          clr_ovf();
          wr16(starts[s]);
          cnt_down = d[0];
          clk_sel = 3'd1;
          step(ks[ki]);
          clk_sel = 3'd0;
          rd16(v);
          sum = {1'b0, starts[s]} + 17'(ks[ki]);
          exp = d[0] ? starts[s] - 16'(ks[ki]) : sum[15:0];
          chk("R2 R9 count", v, exp);
          chk("R12 ovf sweep", ovf_flag, (!d[0] && sum[16]) ? 1'b1 : 1'b0);
        end
      end
    end
    cnt_down = 1'b0;

    // R11 status flags
    wr16(16'hFFFF);
    chk("R11 top", {at_top, at_bottom}, 2'b10);
    wr16(16'h0000);
    chk("R11 bottom", {at_top, at_bottom}, 2'b01);
    wr16(16'h0001);
    chk("R11 middle", {at_top, at_bottom}, 2'b00);

    // R4 high write changes only the holding register
    wr16(16'h3344);
    @(negedge clk); bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h99;
    @(negedge clk); bus_wr = 1'b0;
    #1 chk("R4 hold readback", bus_rdata, 8'h99);
    bus_addr = 1'b0; #1 chk("R4 low intact", bus_rdata, 8'h44);
    rd16(v);
    chk("R4 R5 counter high intact", v, 16'h3344);

    // R5 atomic snapshot across a carry while running
    wr16(16'h12FF);
    @(negedge clk); cnt_down = 1'b0; clk_sel = 3'd1; bus_addr = 1'b0; bus_rd = 1'b1;
    #1 v[7:0] = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
    step(1);
    clk_sel = 3'd0;
    bus_addr = 1'b1; #1 v[15:8] = bus_rdata;
    chk("R5 snapshot", v, 16'h12FF);
    rd16(v);
    chk("R5 after run", v, 16'h1301);

    // R7 write beats clear and tick
    @(negedge clk); bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'hAB;
    @(negedge clk); bus_addr = 1'b0; bus_wdata = 8'hCD; clk_sel = 3'd1; cnt_clear = 1'b1;
    @(negedge clk); bus_wr = 1'b0; cnt_clear = 1'b0; clk_sel = 3'd0;
    rd16(v);
    chk("R6 R7 write wins", v, 16'hABCD);

    // R3 clear beats tick
    @(negedge clk); clk_sel = 3'd1; cnt_clear = 1'b1;
    @(negedge clk); clk_sel = 3'd0; cnt_clear = 1'b0;
    rd16(v);
    chk("R3 clear", v, 16'h0000);

    // R8 stopped: strobes and pin ignored
    wr16(16'h4242);
    clk_sel = 3'd0; pre_stb = 4'hF;
    for (int i = 0; i < 6; i++) begin ext_pin = ~ext_pin; step(2); end
    pre_stb = 4'h0; ext_pin = 1'b0; step(4);
    rd16(v);
    chk("R8 stopped", v, 16'h4242);

    // R9 prescaler strobe selection
    for (int s = 2; s <= 5; s++) begin
      int n;
      wr16(16'h0100);
      clk_sel = 3'(s);
      n = 0;
      for (int c = 0; c < 24; c++) begin
        for (int j = 0; j < 4; j++) pre_stb[j] = ((c % (j + 2)) == 0);
        if ((c % s) == 0) n++;
        step(1);
      end
      pre_stb = 4'h0; clk_sel = 3'd0;
      rd16(v);
      chk("R9 prescale", v, 16'h0100 + 16'(n));
    end

    // R10 pin edges per polarity
    for (int s = 6; s <= 7; s++) begin
      wr16(16'h0500);
      ext_pin = 1'b0;
      clk_sel = 3'(s);
      step(4);
      for (int p = 0; p < 5; p++) begin
        ext_pin = 1'b1; step(3);
        ext_pin = 1'b0; step(3);
      end
      step(4);
      clk_sel = 3'd0;
      rd16(v);
      chk("R10 pin edges", v, 16'h0505);
    end

    // R10 latency: pin change before edge k shows after edge k+2
    wr16(16'h0700);
    clk_sel = 3'd7; bus_addr = 1'b0;
    @(negedge clk); ext_pin = 1'b1;
    step(2);
    #1 chk("R10 not yet", bus_rdata, 8'h00);
    step(1);
    #1 chk("R10 latency", bus_rdata, 8'h01);
    ext_pin = 1'b0; step(4); clk_sel = 3'd0;

    // R12 overflow hold, clear, set-wins, down wrap
    clr_ovf();
    wr16(16'hFFFF);
    clk_sel = 3'd1; step(1); clk_sel = 3'd0;
    chk("R12 set", ovf_flag, 1'b1);
    step(5);
    chk("R12 sticky", ovf_flag, 1'b1);
    clr_ovf();
    chk("R12 cleared", ovf_flag, 1'b0);
    wr16(16'hFFFF);
    ovf_clr = 1'b1; clk_sel = 3'd1; step(1); ovf_clr = 1'b0; clk_sel = 3'd0;
    chk("R12 set wins", ovf_flag, 1'b1);
    clr_ovf();
    wr16(16'h0000);
    cnt_down = 1'b1; clk_sel = 3'd1; step(1); clk_sel = 3'd0; cnt_down = 1'b0;
    chk("R12 down wrap", ovf_flag, 1'b0);
    rd16(v);
    chk("R2 down wrap value", v, 16'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule